// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Controller with Distributed Refresh

This block connects a simple host request port to a DRAM device that shares one set of address pins between the row and the column. The host presents a flat word address with a read or write request and keeps the request up until the controller shows ready. The controller then splits the address into a row part and a column part. It drives the row and lowers the row strobe, waits a programmable activate delay, and then drives the column and lowers the column strobe. For a write, the write strobe goes low with the column strobe. For a read, the output enable goes low with the column strobe, and the returned word is captured when the column phase ends. All strobes then go high again for a precharge wait before the controller accepts new work.

A free-running interval timer raises a refresh request once every `REF_INTERVAL` cycles. This value is the total retention period divided by the number of rows. Each request is served as one row-strobe-only cycle on the row named by an internal counter, which advances after every refresh. In this way the rows are refreshed one at a time at evenly spaced points rather than all together. A waiting refresh takes priority over a host request. The host sees ready low for the whole time an access or a refresh is under way or waiting.

Top module: `rowcol_dram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready is high, rd_valid is low, and all four active-low strobes (row, column, write, output enable) are high.
- R2: An accepted request lowers the row strobe in the next cycle and keeps it low for T_RCD cycles with the column strobe high. The column strobe then stays low for T_CL cycles.
- R3: The row strobe stays low for the whole column phase of an access, and the address bus holds the same value for as long as the row strobe is low and the column strobe is high.
- R4: For a write, the write strobe is low exactly while the column strobe is low and the output enable stays high. The device stores the write data at the addressed word.
- R5: For a read, the output enable is low exactly while the column strobe is low and the write strobe stays high. rd_valid pulses for one cycle in the cycle after the column phase, with rd_data holding the word stored at that address.
- R6: After the column phase of an access, or the row phase of a refresh, all strobes stay high for T_RP cycles. After that the block is idle for at least one cycle before the row strobe can fall again.
- R7: A refresh becomes due after every REF_INTERVAL cycles since reset. It is a row-strobe-only cycle lasting T_RAS cycles on the row taken from a counter. The counter starts at 0, advances by one after each refresh and wraps after the last row.
- R8: A due refresh starts before a waiting host request. The request stays held, with ready low, and is accepted once the refresh and its precharge are over.
- R9: Ready is high only when no access or refresh is under way and no refresh is due. A request is accepted on a clock edge where both req_valid and ready are high.
- R10: The row is the upper ROW_W bits of req_addr and the column is the lower COL_W bits. Each is driven on dram_addr, zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_wdata | output | DATA_W | Data to the device |
| dram_rdata | input | DATA_W | Data from the device |

## Verification
The bench uses 3 row bits and 3 column bits, so the 64-word device is small enough to fill completely and read back. It sets T_RCD and T_CL to 2, T_RP to 1 and T_RAS to 3, so each phase is short and the phases are still easy to tell apart. REF_INTERVAL is 40 cycles, so refresh becomes due many times during the run and often falls in the middle of an access. This exercises the held-request priority case, and the refresh row counter wraps around its 8 rows several times.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_COL  = 3'd2,
        ST_PRE  = 3'd3,
        ST_REF  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/rcd_refresh_timer.sv
module rcd_refresh_timer #(
    parameter int INTERVAL = 40,
    parameter int ROW_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             pend;
        logic [ROW_W-1:0] row;
    } rt_t;

    rt_t q, d;
    logic expire;

    always_comb begin
        d      = q;
        expire = (q.tmr == TMR_W'(INTERVAL - 1));
        d.tmr  = expire ? '0 : q.tmr + 1'b1;
        if (ack) begin
            d.row = q.row + 1'b1;
        end
        if (expire) begin
            d.pend = 1'b1;
        end else if (ack) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending = q.pend;
    assign row     = q.row;
endmodule

// File: rtl/rcd_addr_split.sv
module rcd_addr_split #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3,
    parameter int BUS_W = 3
) (
    input  logic [ROW_W+COL_W-1:0] flat,
    output logic [BUS_W-1:0]       row_bus,
    output logic [BUS_W-1:0]       col_bus
);
    generate
        if (ROW_W == BUS_W) begin : g_row_full
            assign row_bus = flat[ROW_W+COL_W-1:COL_W];
        end else begin : g_row_pad
            assign row_bus = {{(BUS_W-ROW_W){1'b0}}, flat[ROW_W+COL_W-1:COL_W]};
        end
        if (COL_W == BUS_W) begin : g_col_full
            assign col_bus = flat[COL_W-1:0];
        end else begin : g_col_pad
            assign col_bus = {{(BUS_W-COL_W){1'b0}}, flat[COL_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/rcd_sequencer.sv
module rcd_sequencer
    import rcd_pkg::*;
#(
    parameter int BUS_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CL   = 2,
    parameter int T_RP   = 1,
    parameter int T_RAS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_row,
    input  logic [BUS_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ref_pending,
    input  logic [BUS_W-1:0]  ref_row,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              ready,
    output logic              ref_ack,
    output logic [BUS_W-1:0]  bus,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int MAX_AB  = (T_RCD > T_CL) ? T_RCD : T_CL;
    localparam int MAX_CD  = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int MAXWAIT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = (MAXWAIT > 1) ? $clog2(MAXWAIT) : 1;

    typedef struct packed {
        seq_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [BUS_W-1:0]  col;
        logic [BUS_W-1:0]  bus;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        ref_ack  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    d.st    = ST_REF;
                    d.bus   = ref_row;
                    d.ras_n = 1'b0;
                    d.cnt   = CNT_W'(T_RAS - 1);
                end else if (req_valid) begin
                    d.st    = ST_ACT;
                    d.bus   = req_row;
                    d.col   = req_col;
                    d.wr    = req_write;
                    d.wdata = req_wdata;
                    d.ras_n = 1'b0;
                    d.cnt   = CNT_W'(T_RCD - 1);
                end
            end
            ST_ACT: begin
                if (q.cnt == '0) begin
                    d.st    = ST_COL;
                    d.bus   = q.col;
                    d.cas_n = 1'b0;
                    d.we_n  = !q.wr;
                    d.oe_n  = q.wr;
                    d.cnt   = CNT_W'(T_CL - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (q.cnt == '0) begin
                    d.st    = ST_PRE;
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.cnt   = CNT_W'(T_RP - 1);
                    if (!q.wr) begin
                        d.rdata  = dram_rdata;
                        d.rvalid = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REF: begin
                if (q.cnt == '0) begin
                    d.st    = ST_PRE;
                    d.ras_n = 1'b1;
                    d.cnt   = CNT_W'(T_RP - 1);
                    ref_ack = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (q.cnt == '0) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready  = (q.st == ST_IDLE) && !ref_pending;
    assign bus    = q.bus;
    assign ras_n  = q.ras_n;
    assign cas_n  = q.cas_n;
    assign we_n   = q.we_n;
    assign oe_n   = q.oe_n;
    assign wdata  = q.wdata;
    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
endmodule

// File: rtl/rowcol_dram_ctrl.sv
module rowcol_dram_ctrl #(
    parameter int ROW_W        = 3,
    parameter int COL_W        = 3,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CL         = 2,
    parameter int T_RP         = 1,
    parameter int T_RAS        = 3,
    parameter int REF_INTERVAL = 40,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    logic [BUS_W-1:0] row_bus, col_bus, ref_row_bus;
    logic [ROW_W-1:0] ref_row;
    logic             ref_pending, ref_ack;

    rcd_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_split (
        .flat    (req_addr),
        .row_bus (row_bus),
        .col_bus (col_bus)
    );

    rcd_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending),
        .row     (ref_row)
    );

    assign ref_row_bus = BUS_W'(ref_row);

    rcd_sequencer #(
        .BUS_W(BUS_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_row     (row_bus),
        .req_col     (col_bus),
        .req_wdata   (req_wdata),
        .ref_pending (ref_pending),
        .ref_row     (ref_row_bus),
        .dram_rdata  (dram_rdata),
        .ready       (req_ready),
        .ref_ack     (ref_ack),
        .bus         (dram_addr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .oe_n        (dram_oe_n),
        .wdata       (dram_wdata),
        .rdata       (rd_data),
        .rvalid      (rd_valid)
    );
endmodule

// File: rtl/rowcol_dram_ctrl_chk.sv
module rowcol_dram_ctrl_chk #(
    parameter int BUS_W   = 3,
    parameter int GAP_MAX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic [BUS_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             ref_ack
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (ref_ack) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    // R4
    we_low_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    // R3
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R9
    ready_strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n));

    // R3
    row_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && dram_cas_n && !$past(dram_ras_n) && $past(dram_cas_n))
        |-> $stable(dram_addr));

    // R5
    rvalid_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(dram_cas_n));

    // R6
    precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> dram_ras_n);

    // R7
    refresh_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_MAX);
endmodule

bind rowcol_dram_ctrl rowcol_dram_ctrl_chk #(
    .BUS_W  (BUS_W),
    .GAP_MAX(REF_INTERVAL + T_RCD + T_CL + 2 * T_RP + T_RAS + 2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .ref_ack    (ref_ack)
);

// File: tb/rowcol_dram_ctrl_test.sv
`timescale 1ns/1ps
module rowcol_dram_ctrl_test;
    localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
    localparam int T_RCD = 2, T_CL = 2, T_RP = 1, T_RAS = 3, REF_I = 40;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int WORDS = 1 << ADDR_W;
    localparam int ROWS = 1 << ROW_W;
    localparam int TA = T_RCD + T_CL + T_RP;
    localparam int TR = T_RAS + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DATA_W-1:0] rd_data, dram_wdata, dram_rdata;
    logic [COL_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;

    always #2 clk = ~clk;

    rowcol_dram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS), .REF_INTERVAL(REF_I)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    // behavioural device
    logic [DATA_W-1:0] dev_mem [WORDS];
    logic [ROW_W-1:0] dev_row = '0;
    logic dev_ras_prev = 1'b1;
    initial for (int i = 0; i < WORDS; i++) dev_mem[i] = '0;
    assign dram_rdata = (!dram_cas_n && !dram_oe_n) ? dev_mem[{dev_row, dram_addr}] : '0;
    always @(posedge clk) begin
        if (dev_ras_prev && !dram_ras_n) dev_row = dram_addr;
        if (!dram_cas_n && !dram_we_n) dev_mem[{dev_row, dram_addr}] = dram_wdata;
        dev_ras_prev = dram_ras_n;
    end

    // reference model
    logic [DATA_W-1:0] ref_mem [WORDS];
    initial for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    int m_op = 0, m_t = 0, m_tmr = 0, m_row = 0, m_rrow = 0;
    bit m_pend = 0, acc_flag = 0, held_seen = 0, held_done = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    int vectors = 0, fails = 0, cycles = 0;

    always @(posedge clk) begin
        bit expire, ack, pre_ready;
        cycles++;
        if (!rst_n) begin
            m_op = 0; m_t = 0; m_tmr = 0; m_row = 0; m_pend = 0; acc_flag = 0;
        end else begin
            pre_ready = (m_op == 0) && !m_pend;
            acc_flag  = pre_ready && req_valid;
            if (acc_flag && held_seen) held_done = 1;
            expire = (m_tmr == REF_I - 1);
            m_tmr  = expire ? 0 : m_tmr + 1;
            ack    = (m_op == 3) && (m_t == T_RAS);
            if (m_op == 0) begin
                if (m_pend) begin
                    m_op = 3; m_t = 1; m_rrow = m_row;
                end else if (req_valid) begin
                    m_op = req_write ? 2 : 1; m_t = 1; m_addr = req_addr;
                    if (req_write) ref_mem[req_addr] = req_wdata;
                end
            end else if (m_t == ((m_op == 3) ? TR : TA)) begin
                m_op = 0;
            end else begin
                m_t++;
            end
            if (ack) m_row = (m_row + 1) % ROWS;
            m_pend = expire ? 1'b1 : (ack ? 1'b0 : m_pend);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit e_rdy, e_ras, e_cas, e_we, e_oe, e_rv, acc;
        int e_addr;
        string tg;
        e_rdy = (m_op == 0) && !m_pend;
        acc = (m_op == 1 || m_op == 2);
        e_ras = !((acc && m_t <= T_RCD + T_CL) || (m_op == 3 && m_t <= T_RAS));
        e_cas = !(acc && m_t > T_RCD && m_t <= T_RCD + T_CL);
        e_we  = !(m_op == 2 && !e_cas);
        e_oe  = !(m_op == 1 && !e_cas);
        e_rv  = (m_op == 1) && (m_t == T_RCD + T_CL + 1);
        if (!rst_n) tg = "R1";
        else if (m_op == 0 && m_pend) tg = "R8";
        else tg = "R9";
        chk(req_ready == e_rdy, tg, req_ready, e_rdy);
        tg = !rst_n ? "R1" : ((m_op != 0 && e_ras) ? "R6" : (m_op == 3 ? "R7" : "R3"));
        chk(dram_ras_n == e_ras, tg, dram_ras_n, e_ras);
        tg = !rst_n ? "R1" : ((m_op != 0 && e_ras) ? "R6" : "R2");
        chk(dram_cas_n == e_cas, tg, dram_cas_n, e_cas);
        chk(dram_we_n == e_we, !rst_n ? "R1" : "R4", dram_we_n, e_we);
        chk(dram_oe_n == e_oe, !rst_n ? "R1" : "R5", dram_oe_n, e_oe);
        chk(rd_valid == e_rv, !rst_n ? "R1" : "R5", rd_valid, e_rv);
        if (e_rv) chk(rd_data == ref_mem[m_addr], "R5", rd_data, ref_mem[m_addr]);
        if (rst_n && !e_ras) begin
            if (m_op == 3) begin
                e_addr = m_rrow;
                chk(dram_addr == e_addr, "R7", dram_addr, e_addr);
            end else begin
                e_addr = (m_t <= T_RCD) ? m_addr[ADDR_W-1:COL_W] : m_addr[COL_W-1:0];
                chk(dram_addr == e_addr, "R10", dram_addr, e_addr);
            end
        end
        if (m_op == 3 && req_valid) held_seen = 1;
    end

    task automatic do_req(input bit w, input int a, input int dat, input int gap);
        @(negedge clk);
        req_valid = 1'b1; req_write = w;
        req_addr = ADDR_W'(a); req_wdata = DATA_W'(dat);
        forever begin
            @(negedge clk);
            if (acc_flag) break;
        end
        req_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R4 fill every word
        for (int a = 0; a < WORDS; a++) do_req(1'b1, a, (a * 37 + 11) & 8'hFF, a % 3);
        // R5 read back
        for (int a = 0; a < WORDS; a++) do_req(1'b0, a, 0, (a * 5) % 4);
        // R10 overwrite with inverse pattern, interleaved reads
        for (int a = WORDS - 1; a >= 0; a--) begin
            do_req(1'b1, a, ~((a * 37 + 11)) & 8'hFF, 0);
            do_req(1'b0, (a * 9) % WORDS, 0, 1);
        end
        // R7 idle stretch so refresh row counter wraps
        repeat (REF_I * (ROWS + 2)) @(negedge clk);
        for (int a = 0; a < WORDS; a += 7) do_req(1'b0, a, 0, 0);
        repeat (20) @(negedge clk);
        // R8 a request was held behind a refresh and then served
        chk(held_seen && held_done, "R8", held_done, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule